// File: doc/BRIEF.md
# Dual Interrupt-Enable Flag Controller

This block keeps a processor's interrupt-enable state in two flags. The live flag gates maskable interrupts. The shadow flag keeps a saved copy of the live flag. The instruction decoder drives one-cycle strobes into the block:

- enable interrupts
- disable interrupts
- return from a non-maskable service routine
- load the accumulator from one of the two special registers

The sequencer also drives one strobe at each instruction boundary. The block takes a level-sensitive maskable request and an active-low non-maskable request. The non-maskable request is edge-triggered.

Acceptance is decided only at an instruction boundary. When the block accepts an interrupt it pulses one acknowledge for one cycle. It also updates the flags. Taking a non-maskable interrupt clears only the live flag, so the shadow flag still holds the state from before. A return strobe copies the shadow flag back into the live flag. The special-register load strobe puts the shadow flag on an output, so the datapath can write it into the parity flag. After an enable strobe, the block waits one more instruction before it accepts a maskable request.

Top module: `irq_enable_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, both flags are clear and both acknowledges are low. A maskable request at the first boundary after reset is not accepted.
- R2: `ei_stb` sets both flags. `di_stb` clears both flags. If both strobes arrive in the same cycle, the clear wins.
- R3: The first boundary after `ei_stb` accepts no maskable request. It only clears the hold-off. The boundary after that one can accept.
- R4: Accepting a maskable request clears both flags.
- R5: Accepting a non-maskable request clears the live flag and leaves the shadow flag unchanged.
- R6: `retn_stb` copies the shadow flag into the live flag.
- R7: In the cycle `ld_spr_stb` is high, `pflag_we` is high and `pflag_bit` equals the shadow flag. In every other cycle, `pflag_we` is low.
- R8: A pending non-maskable request is accepted at a boundary whatever the flag state. A maskable request is accepted at a boundary only when `mreq` is high (1 = requesting), the live flag is set and no hold-off is active.
- R9: When both requests qualify at the same boundary, only the non-maskable one is acknowledged. The two acknowledges are never high together.
- R10: A falling edge on `nmi_n` is synchronised through `SYNC_STAGES` flops and then held as pending until it is accepted. Keeping `nmi_n` low does not cause a second acceptance.
- R11: An acknowledge is a one-cycle pulse. It is high in the cycle after the boundary that accepted the request. No acknowledge is raised without a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ei_stb | input | 1 | Enable-interrupts instruction strobe |
| di_stb | input | 1 | Disable-interrupts instruction strobe |
| retn_stb | input | 1 | Return-from-non-maskable strobe |
| ld_spr_stb | input | 1 | Load accumulator from vector or refresh register strobe |
| boundary | input | 1 | Instruction-boundary strobe |
| mreq | input | 1 | Maskable request, active high level |
| nmi_n | input | 1 | Non-maskable request, falling edge triggered |
| mi_ack | output | 1 | Maskable accept pulse |
| nmi_ack | output | 1 | Non-maskable accept pulse |
| pflag_we | output | 1 | Parity-flag write strobe |
| pflag_bit | output | 1 | Shadow flag value for the parity flag |

## Verification
The bench targets the boundary right after an enable strobe. A design with no hold-off would acknowledge a maskable request one instruction too early. It checks that the shadow flag survives a non-maskable acceptance, both through the parity output and through a later return strobe. A design that cleared both flags there would lose the restored enable. Further checks cover `nmi_n` held low across several boundaries, a pending edge that waits many cycles for a boundary, and a request pair at a single boundary. Faults here would show as repeated acceptances, a dropped pending request, or two acknowledges in one cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_MASK = 2'd1,
    ACC_NMI  = 2'd2
  } acc_kind_e;

  typedef struct packed {
    logic set_en;
    logic clr_en;
    logic restore;
  } flag_cmd_t;
endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic take,
  output logic pending
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic prev_q, prev_d;
  logic pend_q, pend_d;
  logic level, fall;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign sync_d = nmi_n;
    end else begin : g_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], nmi_n};
    end
  endgenerate

  assign level = sync_q[LAST];

  always_comb begin
    fall   = prev_q & ~level;
    prev_d = level;
    pend_d = fall | (pend_q & ~take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
  import irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_cmd_t cmd,
  input  logic      boundary,
  input  acc_kind_e kind,
  output logic      live,
  output logic      shadow,
  output logic      inhibit
);
  logic live_q, live_d;
  logic shadow_q, shadow_d;
  logic inh_q, inh_d;
  logic en;

  always_comb begin
    live_d   = live_q;
    shadow_d = shadow_q;
    unique case (kind)
      ACC_NMI: live_d = 1'b0;
      ACC_MASK: begin
        live_d   = 1'b0;
        shadow_d = 1'b0;
      end
      default: begin
        if (cmd.clr_en) begin
          live_d   = 1'b0;
          shadow_d = 1'b0;
        end else if (cmd.set_en) begin
          live_d   = 1'b1;
          shadow_d = 1'b1;
        end else if (cmd.restore) begin
          live_d = shadow_q;
        end
      end
    endcase
    if (cmd.set_en)    inh_d = 1'b1;
    else if (boundary) inh_d = 1'b0;
    else               inh_d = inh_q;
    en = boundary | cmd.set_en | cmd.clr_en | cmd.restore;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= 1'b0;
      shadow_q <= 1'b0;
      inh_q    <= 1'b0;
    end else if (en) begin
      live_q   <= live_d;
      shadow_q <= shadow_d;
      inh_q    <= inh_d;
    end
  end

  assign live    = live_q;
  assign shadow  = shadow_q;
  assign inhibit = inh_q;
endmodule

// File: rtl/irq_accept_arb.sv
module irq_accept_arb
  import irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      boundary,
  input  logic      nmi_pend,
  input  logic      mreq,
  input  logic      live,
  input  logic      inhibit,
  output acc_kind_e kind,
  output logic      mi_ack,
  output logic      nmi_ack
);
  logic mi_q, mi_d, nmi_q, nmi_d;

  always_comb begin
    kind = ACC_NONE;
    if (boundary) begin
      if (nmi_pend)                      kind = ACC_NMI;
      else if (mreq && live && !inhibit) kind = ACC_MASK;
    end
    mi_d  = (kind == ACC_MASK);
    nmi_d = (kind == ACC_NMI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mi_q  <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      mi_q  <= mi_d;
      nmi_q <= nmi_d;
    end
  end

  assign mi_ack  = mi_q;
  assign nmi_ack = nmi_q;
endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ei_stb,
  input  logic di_stb,
  input  logic retn_stb,
  input  logic ld_spr_stb,
  input  logic boundary,
  input  logic mreq,
  input  logic nmi_n,
  output logic mi_ack,
  output logic nmi_ack,
  output logic pflag_we,
  output logic pflag_bit
);
  flag_cmd_t cmd;
  acc_kind_e kind;
  logic nmi_pend, live_q, shadow_q, inhibit_q, nmi_take;

  assign cmd.set_en  = ei_stb;
  assign cmd.clr_en  = di_stb;
  assign cmd.restore = retn_stb;
  assign nmi_take    = (kind == ACC_NMI);

  irq_nmi_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .take(nmi_take), .pending(nmi_pend)
  );

  irq_flag_regs u_flags (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .boundary(boundary), .kind(kind),
    .live(live_q), .shadow(shadow_q), .inhibit(inhibit_q)
  );

  irq_accept_arb u_arb (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .nmi_pend(nmi_pend),
    .mreq(mreq), .live(live_q), .inhibit(inhibit_q), .kind(kind),
    .mi_ack(mi_ack), .nmi_ack(nmi_ack)
  );

  assign pflag_we  = ld_spr_stb;
  assign pflag_bit = shadow_q;
endmodule

// File: rtl/irq_enable_ctrl_chk.sv
module irq_enable_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ei_stb,
  input logic di_stb,
  input logic retn_stb,
  input logic boundary,
  input logic mi_ack,
  input logic nmi_ack,
  input logic pflag_bit,
  input logic live,
  input logic shadow,
  input logic inhibit
);
  assert_one_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mi_ack && nmi_ack));

  assert_ack_needs_boundary_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mi_ack || nmi_ack) |-> $past(boundary));

  assert_mi_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mi_ack |=> !mi_ack);

  assert_mi_clears_shadow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mi_ack |-> (!pflag_bit && !live));

  assert_mi_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mi_ack |-> $past(live && !inhibit));

  assert_ei_sets_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ei_stb && !di_stb && !boundary) |-> (live && shadow));

  assert_nmi_keeps_shadow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_ack |-> (!live && shadow == $past(shadow)));

  assert_retn_restores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(retn_stb && !boundary && !ei_stb && !di_stb) |-> (live == $past(shadow)));
endmodule

bind irq_enable_ctrl irq_enable_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ei_stb(ei_stb), .di_stb(di_stb), .retn_stb(retn_stb),
  .boundary(boundary), .mi_ack(mi_ack), .nmi_ack(nmi_ack), .pflag_bit(pflag_bit),
  .live(live_q), .shadow(shadow_q), .inhibit(inhibit_q)
);

// File: tb/irq_enable_ctrl_tb.sv
module irq_enable_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ei_stb = 1'b0, di_stb = 1'b0, retn_stb = 1'b0, ld_spr_stb = 1'b0;
  logic boundary = 1'b0, mreq = 1'b0, nmi_n = 1'b1;
  logic mi_ack, nmi_ack, pflag_we, pflag_bit;
  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_enable_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ei_stb(ei_stb), .di_stb(di_stb), .retn_stb(retn_stb),
    .ld_spr_stb(ld_spr_stb), .boundary(boundary), .mreq(mreq), .nmi_n(nmi_n),
    .mi_ack(mi_ack), .nmi_ack(nmi_ack), .pflag_we(pflag_we), .pflag_bit(pflag_bit)
  );

  // vector: {ei,di,retn,ld,bnd,mreq, exp mi_ack, exp nmi_ack, exp pflag_we, exp pflag_bit}
  localparam int NV = 17;
  localparam logic [9:0] VEC [NV] = '{
    10'b0000110000, // R1 disabled after reset
    10'b0001000010, // R7 shadow 0
    10'b1000000000, // R2 enable
    10'b0000110000, // R3 hold-off boundary
    10'b0000111000, // R3 accepted one later
    10'b0001000010, // R4 shadow cleared
    10'b0000110000, // R4 live cleared
    10'b1000000000,
    10'b0000100000,
    10'b0001000011, // R2 shadow set
    10'b0100000000, // R2 disable
    10'b0001000010,
    10'b0000110000, // R8 refused when disabled
    10'b1000000000,
    10'b0000100000,
    10'b0000010000, // R11 no boundary, no ack
    10'b0000111000
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic [9:0] v, input string req);
    {ei_stb, di_stb, retn_stb, ld_spr_stb, boundary, mreq} = v[9:4];
    #1;
    check({req, " R7 pflag"}, {pflag_we, pflag_bit & v[6]}, {v[1], v[0] & v[6]});
    @(negedge clk);
    check({req, " acks"}, {mi_ack, nmi_ack}, v[3:2]);
    {ei_stb, di_stb, retn_stb, ld_spr_stb, boundary, mreq} = '0;
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(10'b0, req);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset acks", {mi_ack, nmi_ack}, 2'b00);
    check("R1 reset pflag_we", {1'b0, pflag_we}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NV; k++) step(VEC[k], "table");

    // R5 R6 R9 R10: NMI with maskable also asked
    step(10'b1000000000, "R2");
    step(10'b0000100000, "R3");
    nmi_n = 1'b0;
    idle(4, "R10 sync");
    step(10'b0000110100, "R9 nmi wins");
    step(10'b0000000000, "R11 pulse");
    step(10'b0001000011, "R5 shadow kept");
    step(10'b0000110000, "R5 live cleared");
    step(10'b0000100000, "R10 held low no retake");
    step(10'b0010000000, "R6 retn");
    step(10'b0000111000, "R6 restored");

    // R8 R10: NMI while disabled, pending waits
    nmi_n = 1'b1;
    idle(3, "R10");
    step(10'b0100000000, "R2 di");
    nmi_n = 1'b0;
    idle(8, "R10 pending waits");
    step(10'b0000100100, "R8 nmi when disabled");
    step(10'b0010000000, "R6 retn");
    step(10'b0000110000, "R6 restored zero");
    step(10'b0001000010, "R7 shadow zero");
    nmi_n = 1'b1;

    // R1: reset mid-run
    step(10'b1000000000, "R2");
    step(10'b0000100000, "R3");
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 acks in reset", {mi_ack, nmi_ack}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    step(10'b0000110000, "R1 disabled after reset");
    step(10'b0001000010, "R1 shadow cleared");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule